// File: doc/BRIEF.md
# Multi-mode flash read interface

This block is a synchronous, device-side model of the read port of a parallel NOR-style flash. The host side drives active-low chip enable, output enable, write enable and address-valid strobes plus an address bus and a 16-bit data input. The block returns 16-bit read data with an output-enable flag. All strobes are sampled on `clk`, so any strobe edge is seen as a change between two successive samples. The storage array sits outside the block. It is reached through a one-word combinational port: the block drives `arr_addr` and the array answers on `arr_rdata` in the same cycle.

Commands written on the data bus pick one of three read modes: array contents, identifier codes or status. A two-write sequence loads a six-bit read configuration, taken from the low address bits. With the default configuration, main-array reads go through a four-word page buffer that a fill state machine loads one word per clock. With the synchronous configuration, a main-array access latches its start address and then presents a burst of words, one per clock, in linear or interleaved order, for 4, 8 or an unbounded number of words, after 0 to 3 wait clocks. Parameter-region addresses (the top `PARAM_WORDS` words), identifier reads and status reads are always single accesses.

The command machine has two states. C_IDLE moves to C_CFG on the setup code, and C_CFG returns to C_IDLE on the next write. The page machine has P_IDLE and P_FILL. P_IDLE moves to P_FILL on a miss, and P_FILL returns to P_IDLE after the fourth word. The burst machine has B_IDLE, B_WAIT, B_RUN and B_HOLD. B_IDLE moves to B_WAIT or B_RUN on a latch. B_WAIT moves to B_RUN when the wait count expires. B_RUN moves to B_HOLD after the last word of a bounded burst. Any state returns to B_IDLE when chip enable goes high.

Top module: `flash_rd_port`

## Requirements
- R1: A command write is recognised on the first clock at which `we_n` is sampled high after being sampled low, with `ce_n` low; `din[7:0]` = 0xFF selects array mode, 0x90 identifier mode, 0x70 status mode, and any other code in C_IDLE leaves the read mode unchanged.
- R2: After reset the block is in array mode with the all-zero configuration (asynchronous page reads).
- R3: A write of 0x60 followed by a write of 0x03 loads the configuration from `addr[5:0]`: bit 0 synchronous, bits 2:1 burst length (0 = 4, 1 = 8, 2 or 3 = continuous), bit 3 interleaved order, bits 5:4 wait clocks; if the second code is not 0x03 the configuration is unchanged.
- R4: In identifier mode the data is 0x00A5 for `addr[1:0]`=0, 0x88C3 for 1 and zero otherwise; in status mode the data is 0x0080.
- R5: In asynchronous array mode a main-region read whose four-word page (address bits above 1:0) is not buffered keeps `dout_en` low for five clocks while the page loads; after that, and for any buffered page, the word selected by `addr[1:0]` is returned without delay.
- R6: In asynchronous mode the address follows `addr` while `adv_n` is low and holds once it is high; in synchronous mode only the first clock with `adv_n` and `ce_n` low captures the address, and later changes are ignored until `adv_n` goes high again.
- R7: In synchronous array mode a main-region latch starts a burst: word j is the array word at the start address plus j, wrapping within an aligned block of 4 or 8 words (linear), or at the start offset XOR j within that block (interleaved), or with no wrap (continuous); word 0 appears after the latching clock, one word per clock after that.
- R8: With a wait setting of n, `dout_en` stays low for n clocks after the latching clock, and the burst sequence is delayed by n clocks.
- R9: A bounded burst holds its last word after the final beat; `ce_n` high ends a burst at any point, even after one word, and a later single read returns the latched address's word.
- R10: Parameter-region, identifier and status reads never page-fill or advance: repeated clocks return the same word.
- R11: `dout_en` is high only while both `ce_n` and `oe_n` are low, and `dout` is zero whenever `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; commands taken on its rising edge |
| adv_n | input | 1 | Address valid, active low; opens the address latch |
| addr | input | AW | Word address; also carries the configuration value |
| din | input | 16 | Write data; command code in bits 7:0 |
| dout | output | 16 | Read data, zero when not enabled |
| dout_en | output | 1 | Read data valid and driven |
| arr_addr | output | AW | Address presented to the array |
| arr_rdata | input | 16 | Array word at `arr_addr`, same cycle |

## Verification
The assertions assume that no command is written and the configuration does not change while a burst is active or waiting. They also assume that the array answers combinationally and that strobe and address inputs are stable around each clock edge. The stimulus drives every input at the falling clock edge. It ends each access by raising `ce_n` for a clock before the next command, and it idles for several clocks after each command, so that any page load started by the write sequence completes before a read is checked. The burst sweep visits every start offset within an eight-word block for each length and order. Expected words are computed from the address arithmetic in the requirements.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int PAGE_BITS  = 2;
    localparam int PAGE_WORDS = 1 << PAGE_BITS;

    localparam logic [7:0] CMD_ARRAY     = 8'hFF;
    localparam logic [7:0] CMD_IDENT     = 8'h90;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_CFG_SETUP = 8'h60;
    localparam logic [7:0] CMD_CFG_OK    = 8'h03;

    localparam logic [15:0] STATUS_READY = 16'h0080;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef struct packed {
        logic [1:0] wait_cyc;
        logic       interleave;
        logic [1:0] blen;
        logic       sync;
    } rd_cfg_t;

    localparam int CFG_W = $bits(rd_cfg_t);
endpackage

// File: rtl/fr_cmd.sv
module fr_cmd
    import fr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [7:0]       wr_data,
    input  logic [CFG_W-1:0] wr_cfg,
    output rd_mode_e         mode,
    output rd_cfg_t          cfg
);
    typedef enum logic {C_IDLE, C_CFG} cmd_st_e;

    cmd_st_e  st, st_nx;
    rd_mode_e mode_nx;
    rd_cfg_t  cfg_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= C_IDLE;
            mode <= RM_ARRAY;
            cfg  <= '0;
        end else begin
            st   <= st_nx;
            mode <= mode_nx;
            cfg  <= cfg_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        mode_nx = mode;
        cfg_nx  = cfg;
        if (wr_fire) begin
            unique case (st)
                C_IDLE: begin
                    case (wr_data)
                        CMD_ARRAY:     mode_nx = RM_ARRAY;
                        CMD_IDENT:     mode_nx = RM_IDENT;
                        CMD_STATUS:    mode_nx = RM_STATUS;
                        CMD_CFG_SETUP: st_nx   = C_CFG;
                        default:       ;
                    endcase
                end
                C_CFG: begin
                    st_nx = C_IDLE;
                    if (wr_data == CMD_CFG_OK) cfg_nx = rd_cfg_t'(wr_cfg);
                end
            endcase
        end
    end

    // R1: the read mode moves only on a recognised write
    p_mode_by_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(wr_fire));

    // R3: the configuration moves only on the confirm write of the sequence
    p_cfg_by_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_fire && st == C_CFG && wr_data == CMD_CFG_OK));
endmodule

// File: rtl/fr_latch.sv
module fr_latch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          sync,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] lat_addr,
    output logic [AW-1:0] rd_addr,
    output logic          fire
);
    logic done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            done     <= 1'b0;
        end else if (ce_n || adv_n) begin
            done <= 1'b0;
        end else begin
            done <= 1'b1;
            if (!sync || !done) lat_addr <= addr;
        end
    end

    assign fire    = sync && !ce_n && !adv_n && !done;
    assign rd_addr = (!sync && !adv_n) ? addr : lat_addr;

    // R6: once captured in synchronous mode, the address holds while adv_n stays low
    p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync && !ce_n && !adv_n && done) |-> $stable(lat_addr));
endmodule

// File: rtl/fr_page.sv
module fr_page
    import fr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [AW-1:0] fill_addr,
    output logic          filling,
    output logic          hit,
    output logic [DW-1:0] word
);
    localparam int TW = AW - PAGE_BITS;

    typedef enum logic {P_IDLE, P_FILL} pg_st_e;

    pg_st_e                 st;
    logic [DW-1:0]          pg_mem [PAGE_WORDS];
    logic [TW-1:0]          tag, ftag;
    logic                   vld;
    logic [PAGE_BITS-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= P_IDLE;
            vld  <= 1'b0;
            tag  <= '0;
            ftag <= '0;
            cnt  <= '0;
            for (int i = 0; i < PAGE_WORDS; i++) pg_mem[i] <= '0;
        end else begin
            unique case (st)
                P_IDLE: begin
                    if (req && !hit) begin
                        st   <= P_FILL;
                        vld  <= 1'b0;
                        ftag <= rd_addr[AW-1:PAGE_BITS];
                        cnt  <= '0;
                    end
                end
                P_FILL: begin
                    pg_mem[cnt] <= arr_rdata;
                    cnt         <= cnt + 1'b1;
                    if (cnt == PAGE_BITS'(PAGE_WORDS - 1)) begin
                        st  <= P_IDLE;
                        vld <= 1'b1;
                        tag <= ftag;
                    end
                end
            endcase
        end
    end

    always_comb begin
        hit       = vld && (tag == rd_addr[AW-1:PAGE_BITS]);
        word      = pg_mem[rd_addr[PAGE_BITS-1:0]];
        filling   = (st == P_FILL);
        fill_addr = {ftag, cnt};
    end

    // R5: a completed load leaves the buffer tagged with the page that was loaded
    p_fill_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld) |-> (tag == $past(ftag)));
endmodule

// File: rtl/fr_burst.sv
module fr_burst
    import fr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          fire,
    input  logic          eligible,
    input  rd_cfg_t       cfg,
    input  logic [AW-1:0] addr,
    output logic          active,
    output logic          waiting,
    output logic [AW-1:0] baddr
);
    typedef enum logic [1:0] {B_IDLE, B_WAIT, B_RUN, B_HOLD} bst_e;

    bst_e          st, st_nx;
    logic [AW-1:0] base, base_nx, k, k_nx;
    logic [1:0]    wcnt, wcnt_nx;
    logic          cont;
    logic [AW-1:0] last, mask, off, kk;

    assign cont = cfg.blen[1];
    assign last = cfg.blen[0] ? AW'(7) : AW'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= B_IDLE;
            base <= '0;
            k    <= '0;
            wcnt <= '0;
        end else begin
            st   <= st_nx;
            base <= base_nx;
            k    <= k_nx;
            wcnt <= wcnt_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        base_nx = base;
        k_nx    = k;
        wcnt_nx = wcnt;
        if (ce_n) begin
            st_nx = B_IDLE;
        end else if (fire) begin
            if (eligible) begin
                base_nx = addr;
                k_nx    = '0;
                wcnt_nx = cfg.wait_cyc;
                st_nx   = (cfg.wait_cyc == 2'd0) ? B_RUN : B_WAIT;
            end else begin
                st_nx = B_IDLE;
            end
        end else begin
            unique case (st)
                B_IDLE: ;
                B_WAIT: begin
                    if (wcnt == 2'd1) st_nx = B_RUN;
                    else              wcnt_nx = wcnt - 2'd1;
                end
                B_RUN: begin
                    if (!cont && k == last) st_nx = B_HOLD;
                    else                    k_nx  = k + AW'(1);
                end
                B_HOLD: ;
            endcase
        end
    end

    always_comb begin
        active  = (st == B_RUN) || (st == B_HOLD);
        waiting = (st == B_WAIT);
        mask    = cont ? '0 : last;
        off     = base & mask;
        kk      = k & mask;
        if (cont)                baddr = base + k;
        else if (cfg.interleave) baddr = (base & ~mask) | ((off ^ kk) & mask);
        else                     baddr = (base & ~mask) | ((off + kk) & mask);
    end

    // R7: consecutive beats of a running burst step the beat index by one
    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_RUN) && $past(st == B_RUN && !fire && !ce_n) |-> (k == $past(k) + AW'(1)));

    // R7: a bounded burst never runs past its configured length
    p_burst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_RUN) && !cont |-> (k <= last));
endmodule

// File: rtl/flash_rd_port.sv
module flash_rd_port
    import fr_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          DW          = 16,
    parameter int          PARAM_WORDS = 16,
    parameter logic [15:0] MFR_CODE    = 16'h00A5,
    parameter logic [15:0] DEV_CODE    = 16'h88C3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_rdata
);
    localparam logic [AW:0] PBASE = (AW+1)'((1 << AW) - PARAM_WORDS);

    logic          we_q, wr_fire;
    rd_mode_e      mode;
    rd_cfg_t       cfg;
    logic [AW-1:0] lat_addr, rd_addr, fill_addr, baddr;
    logic          fire, rd_param, fire_param;
    logic          pg_req, filling, hit, b_active, b_waiting;
    logic [DW-1:0] pg_word, data;
    logic          ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign wr_fire    = !ce_n && we_n && !we_q;
    assign rd_param   = {1'b0, rd_addr} >= PBASE;
    assign fire_param = {1'b0, addr} >= PBASE;
    assign pg_req     = !ce_n && (mode == RM_ARRAY) && !cfg.sync && !rd_param;

    fr_cmd u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_data (din[7:0]),
        .wr_cfg  (addr[CFG_W-1:0]),
        .mode    (mode),
        .cfg     (cfg)
    );

    fr_latch #(.AW(AW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .sync     (cfg.sync),
        .addr     (addr),
        .lat_addr (lat_addr),
        .rd_addr  (rd_addr),
        .fire     (fire)
    );

    fr_page #(.AW(AW), .DW(DW)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pg_req),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .fill_addr (fill_addr),
        .filling   (filling),
        .hit       (hit),
        .word      (pg_word)
    );

    fr_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .fire     (fire),
        .eligible ((mode == RM_ARRAY) && !fire_param),
        .cfg      (cfg),
        .addr     (addr),
        .active   (b_active),
        .waiting  (b_waiting),
        .baddr    (baddr)
    );

    always_comb begin
        if (filling)       arr_addr = fill_addr;
        else if (b_active) arr_addr = baddr;
        else               arr_addr = rd_addr;
    end

    always_comb begin
        data  = '0;
        ready = 1'b0;
        unique case (mode)
            RM_IDENT: begin
                ready = 1'b1;
                if (rd_addr[1:0] == 2'd0)      data = MFR_CODE;
                else if (rd_addr[1:0] == 2'd1) data = DEV_CODE;
            end
            RM_STATUS: begin
                ready = 1'b1;
                data  = STATUS_READY;
            end
            RM_ARRAY: begin
                if (cfg.sync) begin
                    ready = !b_waiting;
                    data  = arr_rdata;
                end else if (rd_param) begin
                    ready = !filling;
                    data  = arr_rdata;
                end else begin
                    ready = hit;
                    data  = pg_word;
                end
            end
            default: ;
        endcase
        dout_en = !ce_n && !oe_n && ready;
        dout    = dout_en ? data : '0;
    end

    // R10: only array-mode synchronous accesses ever run a burst
    p_burst_in_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_active || b_waiting) |-> (mode == RM_ARRAY && cfg.sync));

    // R5: the page loader never runs in synchronous mode
    p_fill_async_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filling) |-> !cfg.sync);
endmodule

// File: tb/test_flash_rd_port.sv
module test_flash_rd_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, ce_n, oe_n, we_n, adv_n;
    logic [7:0]  addr, arr_addr;
    logic [15:0] din, dout, arr_rdata;
    logic        dout_en;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] arr_f(input logic [7:0] a);
        return {a ^ 8'h3C, a + 8'h51};
    endfunction

    assign arr_rdata = arr_f(arr_addr);

    flash_rd_port i_flash_rd_port (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .adv_n(adv_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] exp_baddr(input logic [7:0] s, input int k,
                                             input logic [1:0] bl, input logic il);
        logic [7:0] m;
        if (bl[1]) return s + 8'(k);
        m = bl[0] ? 8'd7 : 8'd3;
        if (il) return (s & ~m) | (((s & m) ^ 8'(k)) & m);
        return (s & ~m) | (((s & m) + 8'(k)) & m);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic en, input logic [15:0] d);
        #1;
        chk(req, {15'd0, dout_en}, {15'd0, en});
        if (en) chk(req, dout, d);
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr_cmd(input logic [7:0] c, input logic [7:0] a);
        ce_n = 1'b0; oe_n = 1'b1; adv_n = 1'b1; we_n = 1'b0; din = {8'h00, c}; addr = a;
        tick();
        we_n = 1'b1;
        tick();
        idle();
        repeat (5) tick();
    endtask

    task automatic set_cfg(input logic sy, input logic [1:0] bl, input logic il, input logic [1:0] w);
        wr_cmd(8'h60, 8'h00);
        wr_cmd(8'h03, {2'b00, w, il, bl, sy});
    endtask

    task automatic run_burst(input logic [7:0] s, input logic [1:0] bl, input logic il,
                             input logic [1:0] w, input int nw);
        set_cfg(1'b1, bl, il, w);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = s;
        tick();
        adv_n = 1'b1; addr = 8'h00;
        for (int i = 0; i < int'(w); i++) begin
            chk_rd("R8 wait clock", 1'b0, 16'h0);
            tick();
        end
        for (int j = 0; j < nw; j++) begin
            int lim = bl[0] ? 8 : 4;
            int jj  = (bl[1] || j < lim) ? j : lim - 1;
            chk_rd(bl[1] ? "R7 continuous" : (j < lim ? "R7 burst beat" : "R9 hold last"),
                   1'b1, arr_f(exp_baddr(s, jj, bl, il)));
            tick();
        end
        idle();
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; idle(); addr = '0; din = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_rd("R11 reset idle", 1'b0, 16'h0);

        // R2 / R5: default asynchronous page read of a main-region page
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'h34;
        chk_rd("R2 R5 page miss", 1'b0, 16'h0);
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk_rd("R5 page load", i == 5, arr_f(8'h34));
        end
        for (int o = 0; o < 4; o++) begin
            addr = {6'b001101, 2'(o)};
            chk_rd("R5 page hit", 1'b1, arr_f({6'b001101, 2'(o)}));
        end
        // R6 asynchronous latch
        addr = 8'h37; tick();
        adv_n = 1'b1; addr = 8'h90;
        chk_rd("R6 async hold", 1'b1, arr_f(8'h37));
        addr = 8'h05;
        chk_rd("R6 async hold", 1'b1, arr_f(8'h37));
        adv_n = 1'b0; addr = 8'h91;
        chk_rd("R5 new page miss", 1'b0, 16'h0);
        repeat (5) tick();
        chk_rd("R5 new page", 1'b1, arr_f(8'h91));
        // R11 enables
        oe_n = 1'b1;
        chk_rd("R11 oe high", 1'b0, 16'h0);
        chk("R11 dout zero", dout, 16'h0);
        oe_n = 1'b0; ce_n = 1'b1;
        chk_rd("R11 ce high", 1'b0, 16'h0);
        // R10 asynchronous parameter region
        ce_n = 1'b0;
        for (int a = 8'hF0; a <= 8'hFF; a++) begin
            addr = 8'(a);
            chk_rd("R10 param async", 1'b1, arr_f(8'(a)));
        end
        addr = 8'hF3; tick(); tick();
        chk_rd("R10 param repeat", 1'b1, arr_f(8'hF3));
        addr = 8'hEF;
        chk_rd("R10 main boundary", 1'b0, 16'h0);
        idle(); repeat (6) tick();

        // R4 identifier and status
        wr_cmd(8'h90, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0;
        for (int o = 0; o < 4; o++) begin
            addr = 8'h40 + 8'(o);
            chk_rd("R4 ident", 1'b1, o == 0 ? 16'h00A5 : (o == 1 ? 16'h88C3 : 16'h0000));
        end
        tick(); tick();
        chk_rd("R10 ident repeat", 1'b1, 16'h0000);
        idle(); tick();
        wr_cmd(8'h70, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'h60;
        chk_rd("R4 status", 1'b1, 16'h0080);
        addr = 8'hF1;
        chk_rd("R4 status", 1'b1, 16'h0080);
        addr = 8'h60;
        idle(); tick();
        wr_cmd(8'h11, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0;
        chk_rd("R1 unknown code ignored", 1'b1, 16'h0080);
        idle(); tick();
        wr_cmd(8'hFF, 8'h00);
        wr_cmd(8'h42, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'hF7;
        chk_rd("R1 array mode kept", 1'b1, arr_f(8'hF7));
        idle(); tick();

        // R3 aborted configuration sequence keeps asynchronous mode
        wr_cmd(8'h60, 8'h00);
        wr_cmd(8'h55, 8'h01);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'h0B;
        tick();
        chk_rd("R3 config unchanged", 1'b0, 16'h0);
        idle(); repeat (6) tick();

        // R6 / R10 synchronous single reads in the parameter region
        set_cfg(1'b1, 2'd0, 1'b0, 2'd0);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'hF4;
        tick();
        chk_rd("R6 sync capture", 1'b1, arr_f(8'hF4));
        addr = 8'hF9;
        tick();
        chk_rd("R6 sync ignore change", 1'b1, arr_f(8'hF4));
        adv_n = 1'b1; tick();
        adv_n = 1'b0; tick();
        chk_rd("R6 sync recapture", 1'b1, arr_f(8'hF9));
        adv_n = 1'b1; tick(); tick();
        chk_rd("R10 param no advance", 1'b1, arr_f(8'hF9));
        idle(); tick();

        // R9 burst ended after one word
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'h50;
        tick();
        adv_n = 1'b1;
        chk_rd("R9 first word", 1'b1, arr_f(8'h50));
        ce_n = 1'b1;
        chk_rd("R9 end by ce", 1'b0, 16'h0);
        tick();
        ce_n = 1'b0;
        chk_rd("R9 single after end", 1'b1, arr_f(8'h50));
        tick();
        chk_rd("R9 no resume", 1'b1, arr_f(8'h50));
        idle(); tick();

        // R7 sweep: every start offset, both orders, all lengths
        for (int bl = 0; bl < 3; bl++)
            for (int il = 0; il < 2; il++)
                for (int o = 0; o < 8; o++)
                    run_burst(8'h20 + 8'(o), 2'(bl), 1'(il), 2'd0, (bl == 0) ? 6 : 10);
        run_burst(8'hEA, 2'd2, 1'b0, 2'd0, 12);
        // R8 wait clocks
        for (int w = 1; w < 4; w++) begin
            run_burst(8'h45, 2'd0, 1'b0, 2'(w), 5);
            run_burst(8'h6E, 2'd1, 1'b1, 2'(w), 9);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule